// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits beside a byte-wide non-volatile array and watches the host's write cycles as address/data pairs. It recognises multi-cycle unlock commands that all share the same two-cycle opening and then branch: short three-cycle commands and longer six- and seven-cycle commands. From them it keeps a software write-protection flag and two boot-region lockout flags, opens a timed page-load window, starts a chip erase, and enters or leaves a product-identification mode in which reads return identification and lockout status bytes.

Write cycles that arrive while the decoder is idle and do not open a command are data writes. The block decides whether each one may reach the array. It does so from the protection flag, the load window, the identification mode and the lockout region the address falls in. The protection and lockout flags are kept across the ordinary reset. Only a separate cold-initialisation input returns them to their shipped state.

Top module: `cmdseq_decoder`

## Requirements
- R1: A command always begins with data AA at address 5555 and then data 55 at address 2AAA. For these and all later command cycles except the seventh lockout cycle, only address bits 14..0 are compared.
- R2: A data write is a write taken while the decoder is idle whose pair is not AA at 5555. It raises `array_wr` for exactly the next cycle only when protection is off or the load window is open, and ID mode is off.
- R3: The third cycle A0 at 5555 sets protection on and opens the load window for LOAD_WIN cycles. Each accepted data write reloads the window. When the window has expired, data writes are refused again while protection is on.
- R4: The six-cycle command whose third byte is 80 and whose sixth byte is 20 (both at 5555) turns protection off.
- R5: The six-cycle command ending in 10 gives a one-cycle `erase_start` pulse in the cycle after its last write, but only while neither lockout flag is set.
- R6: ID mode is entered by the three-cycle command with third byte 90 or by the six-cycle command ending in 60. It is left by the three-cycle command with third byte F0, by `rst`, or by `cold_init`.
- R7: `rd_data` follows `rd_addr` in the same cycle. In ID mode, address 00000 gives DA and 00001 gives 45. Address 00002 gives FF if the low region is locked and FE if not. Address 3FFF2 gives the same for the high region. Every other case gives 00.
- R8: The six-cycle command ending in 40 waits for a seventh write, compared on the full address. Data 00 at 00000 sets `lock_lo`, data FF at 3FFFF sets `lock_hi`, and any other seventh write sets nothing.
- R9: With `lock_lo` set, data writes whose address bits 17..13 are all zero never raise `array_wr`. With `lock_hi` set, the same holds for addresses whose bits 17..13 are all one.
- R10: A write that does not match the expected next step returns the decoder to idle, and that write is not a data write. If the mismatching write is AA at 5555, it counts as a new first step.
- R11: `cold_init` sets protection on and clears both lockout flags. `rst` leaves protection and the lockout flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset of sequence state, ID mode, load window and pulses |
| cold_init | input | 1 | Synchronous cold initialisation; also restores persistent flags |
| wr_valid | input | 1 | One host write cycle this clock |
| wr_addr | input | 18 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 18 | Read address |
| rd_data | output | 8 | ID-mode read data (00 when not applicable) |
| prot_on | output | 1 | Software write protection active |
| load_open | output | 1 | Protected page-load window open |
| id_mode | output | 1 | Product identification mode active |
| lock_lo | output | 1 | Low 8 KB region locked |
| lock_hi | output | 1 | High 8 KB region locked |
| erase_start | output | 1 | One-cycle chip-erase start pulse |
| array_wr | output | 1 | One-cycle pulse: the previous write is accepted as array data |

## Verification
Every flag and pulse is registered once. Each is therefore due in the cycle after the clock edge that takes the final write of its command, while `rd_data` is combinational and due in the same cycle as `rd_addr`. The bench drives each write on a falling edge and removes it at the next falling edge. It reads the registered outputs at that second falling edge, so the one-cycle pulses of `erase_start` and `array_wr` are sampled in their only valid cycle. Read data is sampled 1 ns after `rd_addr` changes. The load-window expiry is checked after LOAD_WIN+2 idle cycles. A sweep covers every other third byte after the common opening.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

    // Command address keys (compared on the low command bits only)
    localparam logic [14:0] KEY_ADDR_A = 15'h5555;
    localparam logic [14:0] KEY_ADDR_B = 15'h2AAA;

    // Command data bytes
    localparam logic [7:0] BY_OPEN1   = 8'hAA;
    localparam logic [7:0] BY_OPEN2   = 8'h55;
    localparam logic [7:0] BY_PROT    = 8'hA0;
    localparam logic [7:0] BY_LONG    = 8'h80;
    localparam logic [7:0] BY_ID3     = 8'h90;
    localparam logic [7:0] BY_IDX     = 8'hF0;
    localparam logic [7:0] BY_UNPROT  = 8'h20;
    localparam logic [7:0] BY_ERASE   = 8'h10;
    localparam logic [7:0] BY_ID6     = 8'h60;
    localparam logic [7:0] BY_LOCK    = 8'h40;

    // Identification read values
    localparam logic [7:0] ID_VENDOR  = 8'hDA;
    localparam logic [7:0] ID_PART    = 8'h45;
    localparam logic [7:0] ID_LOCKED  = 8'hFF;
    localparam logic [7:0] ID_OPEN    = 8'hFE;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_GOT_AA, SQ_GOT_55, SQ_LONG, SQ_LONG_AA, SQ_LONG_55, SQ_LOCK
    } seq_t;

    typedef enum logic [3:0] {
        EV_NONE, EV_DATA, EV_PROT_ON, EV_PROT_OFF, EV_ERASE,
        EV_ID_ON, EV_ID_OFF, EV_LOCK_LO, EV_LOCK_HI
    } evt_t;

endpackage

// File: rtl/cmdseq_fsm.sv
module cmdseq_fsm
    import cmdseq_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int CMD_W  = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output evt_t              evt
);
    seq_t state, nxt;

    logic [CMD_W-1:0] cmd_a;
    logic at_a, at_b, is_open, is_second;

    assign cmd_a     = wr_addr[CMD_W-1:0];
    assign at_a      = (cmd_a == CMD_W'(KEY_ADDR_A));
    assign at_b      = (cmd_a == CMD_W'(KEY_ADDR_B));
    assign is_open   = at_a && (wr_data == BY_OPEN1);
    assign is_second = at_b && (wr_data == BY_OPEN2);

    always_comb begin
        nxt = state;
        evt = EV_NONE;
        if (wr_valid) begin
            // default on mismatch: back to idle, or restart on AA@5555
            nxt = is_open ? SQ_GOT_AA : SQ_IDLE;
            unique case (state)
                SQ_IDLE: if (!is_open) evt = EV_DATA;
                SQ_GOT_AA: if (is_second) nxt = SQ_GOT_55;
                SQ_GOT_55: if (at_a) begin
                    unique case (wr_data)
                        BY_PROT: begin evt = EV_PROT_ON; nxt = SQ_IDLE; end
                        BY_ID3:  begin evt = EV_ID_ON;   nxt = SQ_IDLE; end
                        BY_IDX:  begin evt = EV_ID_OFF;  nxt = SQ_IDLE; end
                        BY_LONG: nxt = SQ_LONG;
                        default: ;
                    endcase
                end
                SQ_LONG: if (is_open) nxt = SQ_LONG_AA;
                SQ_LONG_AA: if (is_second) nxt = SQ_LONG_55;
                SQ_LONG_55: if (at_a) begin
                    unique case (wr_data)
                        BY_UNPROT: begin evt = EV_PROT_OFF; nxt = SQ_IDLE; end
                        BY_ERASE:  begin evt = EV_ERASE;    nxt = SQ_IDLE; end
                        BY_ID6:    begin evt = EV_ID_ON;    nxt = SQ_IDLE; end
                        BY_LOCK:   nxt = SQ_LOCK;
                        default: ;
                    endcase
                end
                SQ_LOCK: begin
                    if (wr_addr == '0 && wr_data == 8'h00) begin
                        evt = EV_LOCK_LO; nxt = SQ_IDLE;
                    end else if (&wr_addr && wr_data == 8'hFF) begin
                        evt = EV_LOCK_HI; nxt = SQ_IDLE;
                    end
                end
                default: nxt = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= SQ_IDLE;
        else     state <= nxt;
    end

    AST_SEQ_MOVES_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        (state != $past(state)) |-> $past(wr_valid)); // R10

    AST_LOCK_FROM_PREFIX: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_LOCK) |-> ($past(state) == SQ_LOCK || $past(state) == SQ_LONG_55)); // R8

endmodule

// File: rtl/cmdseq_flags.sv
module cmdseq_flags
    import cmdseq_pkg::*;
#(
    parameter int REG_W    = 5,
    parameter int LOAD_WIN = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cold_init,
    input  evt_t             evt,
    input  logic [REG_W-1:0] region,
    output logic             prot_on,
    output logic             load_open,
    output logic             id_mode,
    output logic             lock_lo,
    output logic             lock_hi,
    output logic             erase_start,
    output logic             array_wr
);
    localparam int CNT_W = $clog2(LOAD_WIN + 1);

    logic [CNT_W-1:0] load_cnt;
    logic in_lo, in_hi, accept;

    assign in_lo     = (region == '0);
    assign in_hi     = &region;
    assign load_open = (load_cnt != '0);
    assign accept    = (evt == EV_DATA) && !id_mode && (!prot_on || load_open)
                       && !(lock_lo && in_lo) && !(lock_hi && in_hi);

    // Persistent flags: only cold_init restores them
    always_ff @(posedge clk) begin
        if (cold_init) begin
            prot_on <= 1'b1;
            lock_lo <= 1'b0;
            lock_hi <= 1'b0;
        end else begin
            if (evt == EV_PROT_ON)  prot_on <= 1'b1;
            if (evt == EV_PROT_OFF) prot_on <= 1'b0;
            if (evt == EV_LOCK_LO)  lock_lo <= 1'b1;
            if (evt == EV_LOCK_HI)  lock_hi <= 1'b1;
        end
    end

    // Volatile state
    always_ff @(posedge clk) begin
        if (rst || cold_init) begin
            id_mode     <= 1'b0;
            load_cnt    <= '0;
            erase_start <= 1'b0;
            array_wr    <= 1'b0;
        end else begin
            erase_start <= (evt == EV_ERASE) && !lock_lo && !lock_hi;
            array_wr    <= accept;
            if (evt == EV_ID_ON)  id_mode <= 1'b1;
            if (evt == EV_ID_OFF) id_mode <= 1'b0;
            if (evt == EV_PROT_ON || (accept && load_open))
                load_cnt <= CNT_W'(LOAD_WIN);
            else if (load_open)
                load_cnt <= load_cnt - 1'b1;
        end
    end

    AST_ERASE_UNLOCKED: assert property (@(posedge clk) disable iff (rst || cold_init)
        erase_start |-> (!$past(lock_lo) && !$past(lock_hi))); // R5

    AST_ERASE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst || cold_init)
        erase_start |=> !erase_start); // R5

    AST_PROT_GATE: assert property (@(posedge clk) disable iff (rst || cold_init)
        array_wr |-> ($past(!prot_on) || $past(load_open))); // R2

    AST_NO_WR_IN_ID: assert property (@(posedge clk) disable iff (rst || cold_init)
        array_wr |-> !$past(id_mode)); // R2

    AST_LOCKED_REGION: assert property (@(posedge clk) disable iff (rst || cold_init)
        array_wr |-> !($past(lock_lo) && $past(in_lo)) && !($past(lock_hi) && $past(in_hi))); // R9

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst || cold_init)
        (lock_lo && lock_hi) |=> (lock_lo && lock_hi)); // R11

endmodule

// File: rtl/cmdseq_idread.sv
module cmdseq_idread
    import cmdseq_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              id_mode,
    input  logic              lock_lo,
    input  logic              lock_hi,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam logic [ADDR_W-1:0] HI_STAT = {{(ADDR_W-4){1'b1}}, 4'h2};

    always_comb begin
        rd_data = 8'h00;
        if (id_mode) begin
            if (rd_addr == ADDR_W'(0))      rd_data = ID_VENDOR;
            else if (rd_addr == ADDR_W'(1)) rd_data = ID_PART;
            else if (rd_addr == ADDR_W'(2)) rd_data = lock_lo ? ID_LOCKED : ID_OPEN;
            else if (rd_addr == HI_STAT)    rd_data = lock_hi ? ID_LOCKED : ID_OPEN;
        end
    end

endmodule

// File: rtl/cmdseq_decoder.sv
module cmdseq_decoder
    import cmdseq_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int CMD_W    = 15,
    parameter int BOOT_W   = 13,
    parameter int LOAD_WIN = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cold_init,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              prot_on,
    output logic              load_open,
    output logic              id_mode,
    output logic              lock_lo,
    output logic              lock_hi,
    output logic              erase_start,
    output logic              array_wr
);
    localparam int REG_W = ADDR_W - BOOT_W;

    evt_t evt;

    cmdseq_fsm #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_fsm (
        .clk(clk), .rst(rst || cold_init), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .evt(evt)
    );

    cmdseq_flags #(.REG_W(REG_W), .LOAD_WIN(LOAD_WIN)) u_flags (
        .clk(clk), .rst(rst), .cold_init(cold_init), .evt(evt),
        .region(wr_addr[ADDR_W-1:BOOT_W]),
        .prot_on(prot_on), .load_open(load_open), .id_mode(id_mode),
        .lock_lo(lock_lo), .lock_hi(lock_hi),
        .erase_start(erase_start), .array_wr(array_wr)
    );

    cmdseq_idread #(.ADDR_W(ADDR_W)) u_id (
        .id_mode(id_mode), .lock_lo(lock_lo), .lock_hi(lock_hi),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

endmodule

// File: tb/sim_cmdseq_decoder.sv
module sim_cmdseq_decoder;
    localparam int LOAD_WIN = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cold_init = 1'b1;
    logic        wr_valid = 1'b0;
    logic [17:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [17:0] rd_addr = '0;
    logic [7:0]  rd_data;
    logic prot_on, load_open, id_mode, lock_lo, lock_hi, erase_start, array_wr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cmdseq_decoder #(.LOAD_WIN(LOAD_WIN)) u0 (
        .clk(clk), .rst(rst), .cold_init(cold_init), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .prot_on(prot_on), .load_open(load_open), .id_mode(id_mode),
        .lock_lo(lock_lo), .lock_hi(lock_hi), .erase_start(erase_start),
        .array_wr(array_wr)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [17:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic seq3(input logic [7:0] d);
        wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, d);
    endtask

    task automatic seq6(input logic [7:0] d);
        seq3(8'h80);
        wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, d);
    endtask

    task automatic rd(input string tag, input logic [17:0] a, input logic [7:0] exp);
        rd_addr = a; #1;
        chk(tag, rd_data, exp);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0; cold_init = 1'b0;
        @(negedge clk);
        // Reset state
        chk("R11 prot_on after cold init", 8'(prot_on), 8'd1);
        chk("R11 locks clear after cold init", 8'({lock_lo, lock_hi}), 8'd0);
        chk("R6 id_mode off after reset", 8'(id_mode), 8'd0);
        chk("R3 load closed after reset", 8'(load_open), 8'd0);
        rd("R7 read outside id mode", 18'h00000, 8'h00);

        wr(18'h04000, 8'h12);
        chk("R2 data refused while protected", 8'(array_wr), 8'd0);

        // R1: aliased upper address bits still decode
        wr(18'h0D555, 8'hAA); wr(18'h3AAAA, 8'h55); wr(18'h0D555, 8'hA0);
        chk("R1 R3 load window open", 8'(load_open), 8'd1);
        wr(18'h04001, 8'h34);
        chk("R3 data accepted in window", 8'(array_wr), 8'd1);
        repeat (LOAD_WIN + 2) @(negedge clk);
        chk("R3 window expired", 8'(load_open), 8'd0);
        wr(18'h04002, 8'h56);
        chk("R3 data refused after expiry", 8'(array_wr), 8'd0);

        // R10 sweep: every non-command third byte leaves state unchanged
        for (int d = 0; d < 256; d++) begin
            if (d == 8'hA0 || d == 8'h90 || d == 8'hF0 || d == 8'h80) continue;
            seq3(8'(d));
            chk("R10 sweep third byte no effect",
                8'({id_mode, load_open, array_wr, prot_on}), 8'b0001);
        end
        // Mismatch followed by a plain data-looking write: must be fresh idle
        wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, 8'hA0);
        wr(18'h04003, 8'h00);
        chk("R3 window reopened after sweep", 8'(array_wr), 8'd1);

        // R10 restart on AA@5555
        wr(18'h05555, 8'hAA); wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, 8'h90);
        chk("R10 R6 restart then id entry", 8'(id_mode), 8'd1);
        rd("R7 vendor byte", 18'h00000, 8'hDA);
        rd("R7 part byte", 18'h00001, 8'h45);
        rd("R7 low region open", 18'h00002, 8'hFE);
        rd("R7 high region open", 18'h3FFF2, 8'hFE);
        rd("R7 other address", 18'h00003, 8'h00);
        seq3(8'hF0);
        chk("R6 id exit", 8'(id_mode), 8'd0);
        rd("R7 read after exit", 18'h00000, 8'h00);

        seq6(8'h20);
        chk("R4 protection off", 8'(prot_on), 8'd0);
        wr(18'h00100, 8'h77);
        chk("R2 data accepted unprotected", 8'(array_wr), 8'd1);

        seq6(8'h60);
        chk("R6 six-cycle id entry", 8'(id_mode), 8'd1);
        wr(18'h04004, 8'h01);
        chk("R2 data refused in id mode", 8'(array_wr), 8'd0);
        @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
        chk("R6 rst leaves id mode", 8'(id_mode), 8'd0);
        chk("R11 rst keeps protection off", 8'(prot_on), 8'd0);

        seq6(8'h10);
        chk("R5 erase pulse", 8'(erase_start), 8'd1);
        @(negedge clk);
        chk("R5 erase pulse one cycle", 8'(erase_start), 8'd0);

        seq6(8'h40); wr(18'h3FFFF, 8'h00);
        chk("R8 wrong seventh write locks nothing", 8'({lock_lo, lock_hi}), 8'd0);
        seq6(8'h40); wr(18'h00000, 8'h00);
        chk("R8 low lock set", 8'({lock_lo, lock_hi}), 8'b10);
        seq3(8'h90);
        rd("R7 low region locked", 18'h00002, 8'hFF);
        rd("R7 high region open", 18'h3FFF2, 8'hFE);
        seq3(8'hF0);
        wr(18'h01FFF, 8'h11);
        chk("R9 low region write blocked", 8'(array_wr), 8'd0);
        wr(18'h02000, 8'h11);
        chk("R9 just above low region accepted", 8'(array_wr), 8'd1);
        seq6(8'h10);
        chk("R5 erase blocked by lock", 8'(erase_start), 8'd0);

        seq6(8'h40); wr(18'h3FFFF, 8'hFF);
        chk("R8 high lock set", 8'(lock_hi), 8'd1);
        wr(18'h3E000, 8'h22);
        chk("R9 high region write blocked", 8'(array_wr), 8'd0);
        wr(18'h3DFFF, 8'h22);
        chk("R9 just below high region accepted", 8'(array_wr), 8'd1);

        @(negedge clk); cold_init = 1'b1; @(negedge clk); cold_init = 1'b0;
        chk("R11 cold init restores protection", 8'(prot_on), 8'd1);
        chk("R11 cold init clears locks", 8'({lock_lo, lock_hi}), 8'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule